// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a singly linked list of command packets held in system memory and forwards their contents to a downstream command consumer. Every node opens with one 32-bit header word: the top byte states how many payload words come right after the header, and the low 24 bits give the address of the next node. After a start strobe the block fetches the header, sends the payload words one by one on a valid/ready stream, and then moves to the linked node. It repeats this until it reaches an address that carries the terminator bit.

When the walk ends, the block raises a one-cycle completion pulse. It also reports the number of nodes it visited and a cycle-cost estimate, built up from a fixed charge per node and a further charge that depends on the length of each non-empty node. A chain that loops back on itself would never end. To stop this, a node budget ends the walk and raises an error flag. The block never writes to memory.

Top module: `chain_walker`

## Requirements
- R1: The start address is cut to its low 24 bits when it is taken. If bit 23 of the node address is set, the walk ends before that node is read. A start address with bit 23 set therefore gives a completion with zero nodes, a cost of 0 and no memory read.
- R2: In a header, bits 31:24 are the payload length (0 to 255 words) and bits 23:0 are the next node address. The bits above 23 of the start address have no effect.
- R3: Memory reads use only bits 20:0 of the node address as a byte address. The header is read at that address and payload word k (k from 0) at that address plus 4*(k+1), wrapping within 21 bits. Every read address is word aligned.
- R4: Each payload word appears exactly once on cmdData, in ascending address order, and a node's payload is finished before the next header is read. No memory read is issued while cmdValid is high.
- R5: While cmdValid is high and cmdReady is low, cmdValid stays high and cmdData stays unchanged.
- R6: A node with length 0 sends nothing on the stream, and the walk continues at its next address.
- R7: costCount is the sum over the visited nodes of 10, plus 5 + length for each node whose length is non-zero.
- R8: nodeCount is the number of headers read in the walk, and it never exceeds NODE_LIMIT.
- R9: If NODE_LIMIT headers have been read and the next address does not have bit 23 set, the walk stops with loopErr set to 1 and nodeCount equal to NODE_LIMIT. A chain that ends within NODE_LIMIT nodes leaves loopErr at 0.
- R10: done is high for exactly one cycle per walk. costCount, nodeCount and loopErr keep their values until the next accepted start, which clears them. A start strobe during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Starts a walk when the block is idle |
| startAddr | input | 32 | First node address (low 24 bits used) |
| memRdEn | output | 1 | One-cycle read request |
| memAddr | output | 21 | Byte address of the requested word |
| memRdData | input | 32 | Returned read word |
| memRdValid | input | 1 | memRdData holds the word for the last request |
| cmdValid | output | 1 | Payload word available |
| cmdData | output | 32 | Payload word |
| cmdReady | input | 1 | Sink accepts the word this cycle |
| done | output | 1 | One-cycle completion pulse |
| loopErr | output | 1 | Walk was stopped by the node budget |
| costCount | output | 32 | Accumulated cost estimate |
| nodeCount | output | 14 | Nodes visited in the last walk |

## Verification
A corrupted remaining-word count or read pointer shows up on the stream within a few cycles. The scoreboard then sees a word that is missing, repeated or out of order, or the node after it starts at the wrong place. A wrong node address or a wrong decode of the terminator changes the visited node set, and this appears at completion as a wrong nodeCount and costCount, or as a walk that never completes. Length and cost arithmetic errors are found against the formula on chains that mix empty nodes, single-word nodes and maximum-length nodes. A fault in the loop budget appears only after the 8192nd header, so a self-linked node is run for the full budget.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;
  localparam int DATA_W      = 32;
  localparam int NODE_AW     = 24;
  localparam int MEM_AW      = 21;
  localparam int LEN_W       = 8;
  localparam int END_BIT     = 23;
  localparam int WORD_BYTES  = 4;
  localparam int NODE_COST   = 10;
  localparam int PAYLOAD_FIX = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_HDR_WAIT, ST_PL_REQ,
    ST_PL_WAIT, ST_PL_SEND, ST_LINK, ST_FINISH
  } walkState_t;

  typedef struct packed {
    logic loadStart;
    logic issueHdr;
    logic latchHdr;
    logic issuePl;
    logic latchPl;
    logic popWord;
    logic followLink;
    logic setErr;
  } walkCtrl_t;

  typedef struct packed {
    logic atEnd;
    logic atLimit;
    logic lenZero;
    logic lastWord;
  } walkStat_t;
endpackage

// File: rtl/chain_walker_ctrl.sv
module chain_walker_ctrl
  import chain_walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStrobe,
  input  logic      memRdValid,
  input  logic      cmdReady,
  input  walkStat_t stat,
  output walkCtrl_t ctrl,
  output logic      cmdValid,
  output logic      done
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    cmdValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startStrobe) begin
          ctrl.loadStart = 1'b1;
          stateNext      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (stat.atEnd) begin
          stateNext = ST_FINISH;
        end else if (stat.atLimit) begin
          ctrl.setErr = 1'b1;
          stateNext   = ST_FINISH;
        end else begin
          ctrl.issueHdr = 1'b1;
          stateNext     = ST_HDR_WAIT;
        end
      end
      ST_HDR_WAIT: begin
        if (memRdValid) begin
          ctrl.latchHdr = 1'b1;
          stateNext     = stat.lenZero ? ST_LINK : ST_PL_REQ;
        end
      end
      ST_PL_REQ: begin
        ctrl.issuePl = 1'b1;
        stateNext    = ST_PL_WAIT;
      end
      ST_PL_WAIT: begin
        if (memRdValid) begin
          ctrl.latchPl = 1'b1;
          stateNext    = ST_PL_SEND;
        end
      end
      ST_PL_SEND: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          ctrl.popWord = 1'b1;
          stateNext    = stat.lastWord ? ST_LINK : ST_PL_REQ;
        end
      end
      ST_LINK: begin
        ctrl.followLink = 1'b1;
        stateNext       = ST_CHECK;
      end
      ST_FINISH: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/chain_walker_dp.sv
module chain_walker_dp
  import chain_walker_pkg::*;
#(
  parameter int NODE_LIMIT = 8192,
  parameter int COST_W     = 32,
  parameter int CNT_W      = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkCtrl_t          ctrl,
  input  logic [DATA_W-1:0]  startAddr,
  input  logic [DATA_W-1:0]  memRdData,
  output walkStat_t          stat,
  output logic [MEM_AW-1:0]  memAddr,
  output logic [DATA_W-1:0]  cmdData,
  output logic [COST_W-1:0]  costCount,
  output logic [CNT_W-1:0]   nodeCount,
  output logic               loopErr
);
  logic [NODE_AW-1:0] curAddr;
  logic [NODE_AW-1:0] nextAddr;
  logic [MEM_AW-1:0]  rdPtr;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   hdrLen;
  logic [COST_W-1:0]  costInc;

  assign hdrLen  = memRdData[DATA_W-1 -: LEN_W];
  assign costInc = COST_W'(NODE_COST) +
                   ((hdrLen != '0) ? (COST_W'(PAYLOAD_FIX) + COST_W'(hdrLen)) : '0);

  assign stat.atEnd    = curAddr[END_BIT];
  assign stat.atLimit  = (nodeCount == CNT_W'(NODE_LIMIT));
  assign stat.lenZero  = (hdrLen == '0);
  assign stat.lastWord = (remain == LEN_W'(1));

  assign memAddr = ctrl.issueHdr ? curAddr[MEM_AW-1:0] : rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      nextAddr  <= '0;
      rdPtr     <= '0;
      remain    <= '0;
      cmdData   <= '0;
      costCount <= '0;
      nodeCount <= '0;
      loopErr   <= 1'b0;
    end else begin
      if (ctrl.loadStart) begin
        curAddr   <= startAddr[NODE_AW-1:0];
        costCount <= '0;
        nodeCount <= '0;
        loopErr   <= 1'b0;
      end
      if (ctrl.latchHdr) begin
        nextAddr  <= memRdData[NODE_AW-1:0];
        remain    <= hdrLen;
        rdPtr     <= curAddr[MEM_AW-1:0] + MEM_AW'(WORD_BYTES);
        nodeCount <= nodeCount + CNT_W'(1);
        costCount <= costCount + costInc;
      end
      if (ctrl.latchPl) cmdData <= memRdData;
      if (ctrl.popWord) begin
        rdPtr  <= rdPtr + MEM_AW'(WORD_BYTES);
        remain <= remain - LEN_W'(1);
      end
      if (ctrl.followLink) curAddr <= nextAddr;
      if (ctrl.setErr)     loopErr <= 1'b1;
    end
  end
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int NODE_LIMIT = 8192,
  parameter int COST_W     = 32,
  localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [31:0]       startAddr,
  output logic              memRdEn,
  output logic [20:0]       memAddr,
  input  logic [31:0]       memRdData,
  input  logic              memRdValid,
  output logic              cmdValid,
  output logic [31:0]       cmdData,
  input  logic              cmdReady,
  output logic              done,
  output logic              loopErr,
  output logic [COST_W-1:0] costCount,
  output logic [CNT_W-1:0]  nodeCount
);
  walkCtrl_t ctrl;
  walkStat_t stat;

  chain_walker_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe),
    .memRdValid(memRdValid), .cmdReady(cmdReady), .stat(stat),
    .ctrl(ctrl), .cmdValid(cmdValid), .done(done)
  );

  chain_walker_dp #(.NODE_LIMIT(NODE_LIMIT), .COST_W(COST_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startAddr(startAddr),
    .memRdData(memRdData), .stat(stat), .memAddr(memAddr),
    .cmdData(cmdData), .costCount(costCount), .nodeCount(nodeCount),
    .loopErr(loopErr)
  );

  assign memRdEn = ctrl.issueHdr | ctrl.issuePl;
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int NODE_LIMIT = 8192,
  parameter int CNT_W      = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             memRdEn,
  input logic [20:0]      memAddr,
  input logic             cmdValid,
  input logic [31:0]      cmdData,
  input logic             cmdReady,
  input logic             done,
  input logic             loopErr,
  input logic [CNT_W-1:0] nodeCount
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));

  // R4
  no_read_while_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !memRdEn);

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr[1:0] == 2'b00));

  // R8
  node_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    nodeCount <= CNT_W'(NODE_LIMIT));

  // R9
  loop_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopErr) |-> (done && nodeCount == CNT_W'(NODE_LIMIT)));
endmodule

bind chain_walker chain_walker_chk #(.NODE_LIMIT(NODE_LIMIT), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memAddr(memAddr),
  .cmdValid(cmdValid), .cmdData(cmdData), .cmdReady(cmdReady),
  .done(done), .loopErr(loopErr), .nodeCount(nodeCount)
);

// File: tb/chain_walker_tb.sv
module chain_walker_tb_top;
  localparam int LIMIT = 8192;
  localparam int CW    = $clog2(LIMIT + 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 1'b0;
  logic [31:0] startAddr = '0;
  logic        memRdEn;
  logic [20:0] memAddr;
  logic [31:0] memRdData;
  logic        memRdValid;
  logic        cmdValid;
  logic [31:0] cmdData;
  logic        cmdReady = 1'b1;
  logic        done;
  logic        loopErr;
  logic [31:0] costCount;
  logic [CW-1:0] nodeCount;

  int checks = 0;
  int errors = 0;
  int rdCount = 0;
  bit readyMode = 1'b0;
  bit stallPending = 1'b0;
  logic [31:0] stallData;
  logic [31:0] mem [int];
  logic [31:0] expQ [$];
  int expCost;
  int expNodes;

  always #4 clk = ~clk;

  chain_walker #(.NODE_LIMIT(LIMIT), .COST_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .startAddr(startAddr),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .memRdValid(memRdValid), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdReady(cmdReady), .done(done), .loopErr(loopErr),
    .costCount(costCount), .nodeCount(nodeCount)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (!rstN) begin
      memRdValid <= 1'b0;
      memRdData  <= '0;
    end else begin
      memRdValid <= memRdEn;
      memRdData  <= mem.exists(int'(memAddr[20:2])) ? mem[int'(memAddr[20:2])] : 32'h0;
    end
  end

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // sink ready driver
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cmdReady = readyMode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn) rdCount++;
      if (stallPending) begin
        check32("R5", {31'b0, cmdValid}, 32'h1, "valid held under stall");
        check32("R5", cmdData, stallData, "data held under stall");
      end
      stallPending = cmdValid && !cmdReady;
      stallData    = cmdData;
      if (cmdValid && cmdReady) begin
        if (expQ.size() == 0) check32("R4", cmdData, 32'hxxxx_xxxx, "unexpected payload word");
        else check32("R4", cmdData, expQ.pop_front(), "payload word");
      end
    end
  end

  // writes a node in walk order and records its expectations (R2, R3, R6, R7)
  task automatic putNode(logic [23:0] addr, int len, logic [23:0] nextA);
    logic [20:0] a;
    mem[int'(addr[20:2])] = {len[7:0], nextA};
    for (int k = 0; k < len; k++) begin
      a = addr[20:0] + 21'(4 * (k + 1));
      mem[int'(a[20:2])] = {8'hC0 ^ len[7:0], addr[7:0], 16'(k * 7 + 3)};
      expQ.push_back({8'hC0 ^ len[7:0], addr[7:0], 16'(k * 7 + 3)});
    end
    expNodes++;
    expCost += 10 + ((len != 0) ? 5 + len : 0);
  endtask

  task automatic newChain();
    mem.delete();
    expQ.delete();
    expCost  = 0;
    expNodes = 0;
  endtask

  task automatic runChain(logic [31:0] sAddr, bit expErr, bit tryRestart);
    int n;
    rdCount = 0;
    @(negedge clk);
    startAddr   = sAddr;
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    if (tryRestart) begin
      repeat (4) @(negedge clk);
      startAddr   = 32'h0080_0000;
      startStrobe = 1'b1;   // R10: must be ignored mid-walk
      @(negedge clk);
      startStrobe = 1'b0;
    end
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check32("R10", {31'b0, done}, 32'h1, "completion seen");
    check32("R7", costCount, 32'(expCost), "cost");
    check32("R8", 32'(nodeCount), 32'(expNodes), "node count");
    check32("R9", {31'b0, loopErr}, {31'b0, expErr}, "loop flag");
    check32("R4", 32'(expQ.size()), 32'h0, "words left unsent");
    @(negedge clk);
    check32("R10", {31'b0, done}, 32'h0, "done is one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check32("R10", {31'b0, done}, 32'h0, "reset done");
    check32("R4", {31'b0, cmdValid}, 32'h0, "reset cmdValid");
    check32("R3", {31'b0, memRdEn}, 32'h0, "reset memRdEn");
    check32("R7", costCount, 32'h0, "reset cost");
    check32("R9", {31'b0, loopErr}, 32'h0, "reset loopErr");

    // R1: terminator in start address, upper bits junk
    newChain();
    runChain(32'hAB80_0010, 1'b0, 1'b0);
    check32("R1", 32'(rdCount), 32'h0, "no reads for ended start");

    // R2 R6 R7: mixed lengths, junk upper start bits, restart ignored
    newChain();
    putNode(24'h000100, 2, 24'h000200);
    putNode(24'h000200, 0, 24'h000300);
    putNode(24'h000300, 3, 24'h800000);
    runChain(32'h5A00_0100, 1'b0, 1'b1);
    check32("R6", 32'(rdCount), 32'd8, "reads for 5 words and 3 headers");

    // R3: 21-bit address wrap and dropped bits 22:21
    newChain();
    putNode(24'h7FFFF8, 3, 24'h600200);
    putNode(24'h600200, 1, 24'hC12345);
    runChain(32'h007F_FFF8, 1'b0, 1'b0);

    // R5 R4: maximum length under random back-pressure
    readyMode = 1'b1;
    newChain();
    putNode(24'h001000, 255, 24'h002000);
    putNode(24'h002000, 1, 24'h800000);
    runChain(32'h0000_1000, 1'b0, 1'b0);
    // R10: results held after completion
    repeat (10) @(negedge clk);
    check32("R10", costCount, 32'(expCost), "cost held");
    check32("R10", 32'(nodeCount), 32'(expNodes), "count held");
    readyMode = 1'b0;

    // R9: self-linked node hits the budget
    newChain();
    mem[int'(24'h000040 >> 2)] = {8'd0, 24'h000040};
    expNodes = LIMIT;
    expCost  = 10 * LIMIT;
    runChain(32'h0000_0040, 1'b1, 1'b0);

    // R9 R10: next start clears the error
    newChain();
    putNode(24'h000500, 1, 24'h800000);
    runChain(32'h0000_0500, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule